// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the short control sequence by which a small 16-bit processor accepts an interrupt. It holds the instruction pointer and the status word, and it makes its decision only at an instruction boundary. When the executing core signals that an instruction has retired, the sequencer looks at the interrupt-enable bit of the status word and at the request line. If either is low, it reports a plain end-of-instruction cycle. If both are high, it enters an interrupt phase.

In the interrupt phase it first fetches a one-byte interrupt number from the interrupt controller. It zero-extends that byte into a 16-bit scratch value. It then pushes the status word to a stack unit, clears the enable bit, and pushes the instruction pointer. Next it reads two single bytes from a vector table whose entries lie four bytes apart. It assembles the handler address from those bytes and loads it into the instruction pointer. Every external step uses a request/acknowledge pair. A stack overflow or a bus read error ends the sequence at once with a failure pulse.

The core may overwrite the instruction pointer and the status word through write strobes, but only while the sequencer is idle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the instruction pointer reads 0x2000, the status word reads 0x0200 (only the enable bit, bit 9, set), the cycle kind is 2'b00 (none) and no request is raised.
- R2: A retire pulse taken while idle, with the enable bit clear or the request line low, gives cycle kind 2'b01 (end of instruction) for exactly one cycle in the next clock, and no request is raised.
- R3: A retire pulse taken while idle, with both the enable bit and the request line high, gives cycle kind 2'b10 (interrupt phase) in the next clock, together with a request for the interrupt number.
- R4: The status word is pushed first, with its value at entry and the enable bit still set. The enable bit (bit 9) is cleared when that push is acknowledged. The instruction pointer is pushed after that.
- R5: The vector low byte is read at address number*4 and the high byte at number*4+1. The number is taken as an unsigned byte, with the upper byte of the scratch value zero, so 0xFF reads 0x03FC and 0x03FD.
- R6: When the high byte is acknowledged, the instruction pointer becomes {high byte, low byte}. The next cycle shows cycle kind 2'b01 with a one-cycle success pulse.
- R7: A push acknowledged with the overflow flag, or a read acknowledged with the error flag, gives one cycle of failure pulse with cycle kind 2'b10, leaves the instruction pointer unchanged, raises no further request and returns to idle.
- R8: Core writes to the instruction pointer or the status word take effect only while idle; during a sequence they are ignored.
- R9: A retire pulse during an active sequence is ignored and starts nothing.
- R10: Status bits CF (0), ZF (6), SF (7) and OF (11), and all other non-enable bits, keep their value through a sequence.
- R11: Each request stays high until its acknowledge is seen, and at most one of the number, push and read requests is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_done | input | 1 | Instruction retired this cycle |
| irq_req | input | 1 | Interrupt request line |
| num_req | output | 1 | Request for the interrupt number |
| num_ack | input | 1 | Interrupt number valid |
| num_data | input | 8 | Interrupt number |
| push_req | output | 1 | Stack push request |
| push_data | output | 16 | Word to push |
| push_ack | input | 1 | Push completed |
| push_ovf | input | 1 | Push failed on overflow (valid with push_ack) |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 16 | Byte read address |
| rd_ack | input | 1 | Read completed |
| rd_data | input | 8 | Byte read data |
| rd_err | input | 1 | Read failed (valid with rd_ack) |
| core_ip_we | input | 1 | Core write strobe for the instruction pointer |
| core_ip_wdata | input | 16 | Core write data for the instruction pointer |
| core_flags_we | input | 1 | Core write strobe for the status word |
| core_flags_wdata | input | 16 | Core write data for the status word |
| ip_out | output | 16 | Current instruction pointer |
| flags_out | output | 16 | Current status word |
| cyc_kind | output | 2 | 00 none, 01 end of instruction, 10 interrupt phase |
| seq_ok | output | 1 | Interrupt entry completed |
| seq_fail | output | 1 | Interrupt entry aborted |

## Verification
The bench targets the edges of the vector arithmetic: numbers 0 and 0xFF, where a design that sign-extended the number or dropped the shift would read the wrong table entry. It checks the ordering of the two pushes against the enable-bit clear. A design that cleared the bit too early would save a status word with interrupts off, and one that cleared it too late would leave the bit set after the first push. It injects an overflow on the first push and a read error on the second byte. A design that kept going would raise a further request or load a half-built instruction pointer. Core writes and retire pulses are also sent in the middle of a sequence, where a design that accepted them would corrupt the saved state or start a second sequence.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_END,
    ST_NUM,
    ST_PUSH_FL,
    ST_PUSH_IP,
    ST_RD_LO,
    ST_RD_HI,
    ST_DONE,
    ST_ABORT
  } seq_state_e;

  typedef enum logic [1:0] {
    CYC_NONE = 2'b00,
    CYC_END  = 2'b01,
    CYC_INTR = 2'b10
  } cyc_kind_e;

  localparam int FL_CF = 0;
  localparam int FL_ZF = 6;
  localparam int FL_SF = 7;
  localparam int FL_IF = 9;
  localparam int FL_OF = 11;

endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      insn_done,
  input  logic      irq_req,
  input  logic      if_flag,
  input  logic      num_ack,
  input  logic      push_ack,
  input  logic      push_ovf,
  input  logic      rd_ack,
  input  logic      rd_err,
  output logic      idle,
  output logic      take_irq,
  output logic      scr_ld,
  output logic      if_clr,
  output logic      lo_ld,
  output logic      ip_ld,
  output logic      num_req,
  output logic      push_req,
  output logic      push_sel_ip,
  output logic      rd_req,
  output logic      rd_hi,
  output cyc_kind_e cyc_kind,
  output logic      seq_ok,
  output logic      seq_fail
);

  seq_state_e state_q, state_d;

  // decision point: only at a retire pulse while idle
  assign idle     = (state_q == ST_IDLE);
  assign take_irq = idle && insn_done && if_flag && irq_req;

  // handshake request levels
  assign num_req     = (state_q == ST_NUM);
  assign push_req    = (state_q == ST_PUSH_FL) || (state_q == ST_PUSH_IP);
  assign push_sel_ip = (state_q == ST_PUSH_IP);
  assign rd_req      = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign rd_hi       = (state_q == ST_RD_HI);

  // datapath events
  assign scr_ld = num_req && num_ack;
  assign if_clr = (state_q == ST_PUSH_FL) && push_ack && !push_ovf;
  assign lo_ld  = (state_q == ST_RD_LO) && rd_ack && !rd_err;
  assign ip_ld  = (state_q == ST_RD_HI) && rd_ack && !rd_err;

  assign seq_ok   = (state_q == ST_DONE);
  assign seq_fail = (state_q == ST_ABORT);

  always_comb begin
    unique case (state_q)
      ST_IDLE:          cyc_kind = CYC_NONE;
      ST_END, ST_DONE:  cyc_kind = CYC_END;
      default:          cyc_kind = CYC_INTR;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take_irq)       state_d = ST_NUM;
        else if (insn_done) state_d = ST_END;
      end
      ST_END:  state_d = ST_IDLE;
      ST_NUM:  if (num_ack) state_d = ST_PUSH_FL;
      ST_PUSH_FL: if (push_ack) state_d = push_ovf ? ST_ABORT : ST_PUSH_IP;
      ST_PUSH_IP: if (push_ack) state_d = push_ovf ? ST_ABORT : ST_RD_LO;
      ST_RD_LO:   if (rd_ack)   state_d = rd_err ? ST_ABORT : ST_RD_HI;
      ST_RD_HI:   if (rd_ack)   state_d = rd_err ? ST_ABORT : ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      ST_ABORT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R2: a plain retire gives one end-of-instruction cycle
  assert_plain_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idle && insn_done && !(if_flag && irq_req) |=> cyc_kind == CYC_END ##1 cyc_kind == CYC_NONE);

  // R3: acceptance opens the interrupt phase with a number request
  assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> num_req && cyc_kind == CYC_INTR);

  // R11: requests are held until acknowledged
  assert_num_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    num_req && !num_ack |=> num_req);
  assert_push_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && !push_ack |=> push_req && $stable(push_sel_ip));
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_hi));
  assert_one_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({num_req, push_req, rd_req}));

  // R7: an error aborts, then the block is idle with nothing pending
  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && push_ack && push_ovf) || (rd_req && rd_ack && rd_err)
      |=> seq_fail ##1 (idle && !num_req && !push_req && !rd_req));

  // R9: a retire pulse during a sequence starts nothing
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && insn_done |-> !take_irq);

endmodule

// File: rtl/irq_arch_regs.sv
module irq_arch_regs
  import irq_seq_pkg::*;
#(
  parameter int          W        = 16,
  parameter logic [W-1:0] IP_RESET = 16'h2000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         idle,
  input  logic         core_ip_we,
  input  logic [W-1:0] core_ip_wdata,
  input  logic         core_flags_we,
  input  logic [W-1:0] core_flags_wdata,
  input  logic         if_clr,
  input  logic         ip_ld,
  input  logic [W-1:0] ip_ld_val,
  input  logic         push_sel_ip,
  output logic [W-1:0] ip_q,
  output logic [W-1:0] flags_q,
  output logic [W-1:0] push_data
);

  localparam logic [W-1:0] IF_MASK     = W'(1) << FL_IF;
  localparam logic [W-1:0] FLAGS_RESET = IF_MASK;

  logic ip_core_wr, fl_core_wr;

  assign ip_core_wr = idle && core_ip_we;
  assign fl_core_wr = idle && core_flags_we;

  assign push_data = push_sel_ip ? ip_q : flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q <= IP_RESET;
    end else if (ip_ld) begin
      ip_q <= ip_ld_val;
    end else if (ip_core_wr) begin
      ip_q <= core_ip_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= FLAGS_RESET;
    end else if (if_clr) begin
      flags_q <= flags_q & ~IF_MASK;
    end else if (fl_core_wr) begin
      flags_q <= core_flags_wdata;
    end
  end

  // R4: the enable bit falls only through the sequence or an idle core write
  assert_if_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_q[FL_IF]) |-> $past(if_clr) || $past(fl_core_wr));

  // R8: outside idle, the pointer moves only on a vector load
  assert_ip_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(idle) && !$past(ip_ld) |-> $stable(ip_q));

  // R10: outside idle, non-enable status bits hold
  assert_flags_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(idle) |-> (flags_q & ~IF_MASK) == ($past(flags_q) & ~IF_MASK));

endmodule

// File: rtl/irq_vec_path.sv
module irq_vec_path #(
  parameter int W           = 16,
  parameter int NUM_W       = 8,
  parameter int STRIDE_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scr_ld,
  input  logic [NUM_W-1:0] num_data,
  input  logic             lo_ld,
  input  logic             rd_req,
  input  logic             rd_hi,
  input  logic [W/2-1:0]   rd_data,
  output logic [W-1:0]     rd_addr,
  output logic [W-1:0]     handler
);

  localparam int BYTE_W = W / 2;
  localparam int SPAN_W = NUM_W + STRIDE_LOG2;

  // vector table entry of a scratch value
  function automatic logic [W-1:0] entry_addr(input logic [W-1:0] scr);
    return scr << STRIDE_LOG2;
  endfunction

  // handler address from its two bytes
  function automatic logic [W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                              input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  logic [W-1:0]      scratch_q;
  logic [BYTE_W-1:0] lo_q;
  logic [W-1:0]      base_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      lo_q      <= '0;
    end else begin
      if (scr_ld) scratch_q <= {{(W-NUM_W){1'b0}}, num_data};
      if (lo_ld)  lo_q      <= rd_data;
    end
  end

  assign base_addr = entry_addr(scratch_q);
  assign rd_addr   = rd_hi ? base_addr + W'(1) : base_addr;
  assign handler   = join_bytes(rd_data, lo_q);

  // R5: the high byte address follows the low one directly
  assert_hi_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && $rose(rd_hi) |-> rd_addr == $past(rd_addr) + W'(1));

  // R5: table accesses stay within the span reachable by one number
  assert_addr_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr >> SPAN_W) == '0);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int           W           = 16,
  parameter int           NUM_W       = 8,
  parameter int           STRIDE_LOG2 = 2,
  parameter logic [W-1:0] IP_RESET    = 16'h2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_done,
  input  logic             irq_req,
  output logic             num_req,
  input  logic             num_ack,
  input  logic [NUM_W-1:0] num_data,
  output logic             push_req,
  output logic [W-1:0]     push_data,
  input  logic             push_ack,
  input  logic             push_ovf,
  output logic             rd_req,
  output logic [W-1:0]     rd_addr,
  input  logic             rd_ack,
  input  logic [W/2-1:0]   rd_data,
  input  logic             rd_err,
  input  logic             core_ip_we,
  input  logic [W-1:0]     core_ip_wdata,
  input  logic             core_flags_we,
  input  logic [W-1:0]     core_flags_wdata,
  output logic [W-1:0]     ip_out,
  output logic [W-1:0]     flags_out,
  output logic [1:0]       cyc_kind,
  output logic             seq_ok,
  output logic             seq_fail
);

  // named internal events
  logic         idle, take_irq, scr_ld, if_clr, lo_ld, ip_ld;
  logic         push_sel_ip, rd_hi;
  logic [W-1:0] handler;
  logic [W-1:0] ip_q, flags_q;
  cyc_kind_e    cyc_kind_w;

  irq_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_done  (insn_done),
    .irq_req    (irq_req),
    .if_flag    (flags_q[FL_IF]),
    .num_ack    (num_ack),
    .push_ack   (push_ack),
    .push_ovf   (push_ovf),
    .rd_ack     (rd_ack),
    .rd_err     (rd_err),
    .idle       (idle),
    .take_irq   (take_irq),
    .scr_ld     (scr_ld),
    .if_clr     (if_clr),
    .lo_ld      (lo_ld),
    .ip_ld      (ip_ld),
    .num_req    (num_req),
    .push_req   (push_req),
    .push_sel_ip(push_sel_ip),
    .rd_req     (rd_req),
    .rd_hi      (rd_hi),
    .cyc_kind   (cyc_kind_w),
    .seq_ok     (seq_ok),
    .seq_fail   (seq_fail)
  );

  irq_vec_path #(
    .W          (W),
    .NUM_W      (NUM_W),
    .STRIDE_LOG2(STRIDE_LOG2)
  ) u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .scr_ld  (scr_ld),
    .num_data(num_data),
    .lo_ld   (lo_ld),
    .rd_req  (rd_req),
    .rd_hi   (rd_hi),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .handler (handler)
  );

  irq_arch_regs #(
    .W       (W),
    .IP_RESET(IP_RESET)
  ) u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .idle            (idle),
    .core_ip_we      (core_ip_we),
    .core_ip_wdata   (core_ip_wdata),
    .core_flags_we   (core_flags_we),
    .core_flags_wdata(core_flags_wdata),
    .if_clr          (if_clr),
    .ip_ld           (ip_ld),
    .ip_ld_val       (handler),
    .push_sel_ip     (push_sel_ip),
    .ip_q            (ip_q),
    .flags_q         (flags_q),
    .push_data       (push_data)
  );

  assign ip_out    = ip_q;
  assign flags_out = flags_q;
  assign cyc_kind  = cyc_kind_w;

  // R6: a completed entry lands on the assembled handler address
  assert_ok_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ip_ld |=> seq_ok && cyc_kind == CYC_END && ip_q == $past(handler));

  // R7: an aborted entry leaves the pointer where it was
  assert_fail_keeps_ip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fail |-> $stable(ip_q) && !seq_ok);

  // R4: the status word is saved with interrupts still enabled
  assert_saved_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && !push_sel_ip |-> push_data[FL_IF]);

endmodule

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        insn_done = 0, irq_req = 0;
  logic        num_req, num_ack = 0;
  logic [7:0]  num_data = 0;
  logic        push_req, push_ack = 0, push_ovf = 0;
  logic [15:0] push_data;
  logic        rd_req, rd_ack = 0, rd_err = 0;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = 0;
  logic        core_ip_we = 0, core_flags_we = 0;
  logic [15:0] core_ip_wdata = 0, core_flags_wdata = 0;
  logic [15:0] ip_out, flags_out;
  logic [1:0]  cyc_kind;
  logic        seq_ok, seq_fail;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_req(irq_req),
    .num_req(num_req), .num_ack(num_ack), .num_data(num_data),
    .push_req(push_req), .push_data(push_data), .push_ack(push_ack), .push_ovf(push_ovf),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
    .core_ip_we(core_ip_we), .core_ip_wdata(core_ip_wdata),
    .core_flags_we(core_flags_we), .core_flags_wdata(core_flags_wdata),
    .ip_out(ip_out), .flags_out(flags_out), .cyc_kind(cyc_kind),
    .seq_ok(seq_ok), .seq_fail(seq_fail)
  );

  int n_checks = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] memb(input int a);
    return 8'((a * 29 + 7) % 256);
  endfunction

  // responder settings and logs
  int lat_num = 0, lat_push = 0, lat_rd = 0;
  int ovf_at = -1;        // index of push that overflows
  int err_addr = -1;      // address that returns a read error
  int push_cnt = 0;
  logic [15:0] pushed[$];
  int          reads[$];
  int cn = 0, cp = 0, cr = 0;

  always @(negedge clk) begin
    if (num_ack) begin num_ack = 0; cn = 0; end
    else if (num_req) begin if (cn >= lat_num) num_ack = 1; else cn++; end
    if (push_ack) begin push_ack = 0; push_ovf = 0; cp = 0; end
    else if (push_req) begin
      if (cp >= lat_push) begin
        push_ack = 1; push_ovf = (push_cnt == ovf_at);
        pushed.push_back(push_data); push_cnt++;
      end else cp++;
    end
    if (rd_ack) begin rd_ack = 0; rd_err = 0; cr = 0; end
    else if (rd_req) begin
      if (cr >= lat_rd) begin
        rd_ack = 1; rd_data = memb(int'(rd_addr)); rd_err = (int'(rd_addr) == err_addr);
        reads.push_back(int'(rd_addr));
      end else cr++;
    end
  end

  // behavioural reference: phase number and architectural values
  int m_ph = 0;
  int m_ip = 'h2000, m_fl = 'h0200, m_num = 0, m_lo = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ip = 'h2000; m_fl = 'h0200; m_num = 0; m_lo = 0;
    end else begin
      case (m_ph)
        0: begin
          if (insn_done) m_ph = ((m_fl & 'h200) != 0 && irq_req) ? 2 : 1;
          if (core_ip_we) m_ip = int'(core_ip_wdata);
          if (core_flags_we) m_fl = int'(core_flags_wdata);
        end
        2: if (num_ack) begin m_num = int'(num_data); m_ph = 3; end
        3: if (push_ack) begin
             if (push_ovf) m_ph = 8; else begin m_fl = m_fl & ~'h200; m_ph = 4; end
           end
        4: if (push_ack) m_ph = push_ovf ? 8 : 5;
        5: if (rd_ack) begin
             if (rd_err) m_ph = 8; else begin m_lo = int'(rd_data); m_ph = 6; end
           end
        6: if (rd_ack) begin
             if (rd_err) m_ph = 8; else begin m_ip = int'(rd_data) * 256 + m_lo; m_ph = 7; end
           end
        default: m_ph = 0;
      endcase
    end
  end

  // compare against the reference every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R3 cycle kind", cyc_kind, (m_ph == 0) ? 0 : (m_ph == 1 || m_ph == 7) ? 1 : 2);
      chk("R6 pointer", ip_out, m_ip);
      chk("R4/R10 status", flags_out, m_fl);
      chk("R11 number req", num_req, m_ph == 2);
      chk("R11 push req", push_req, m_ph == 3 || m_ph == 4);
      if (m_ph == 3) chk("R4 push status", push_data, m_fl);
      if (m_ph == 4) chk("R4 push pointer", push_data, m_ip);
      chk("R11 read req", rd_req, m_ph == 5 || m_ph == 6);
      if (m_ph == 5 || m_ph == 6) chk("R5 read addr", rd_addr, m_num * 4 + (m_ph == 6 ? 1 : 0));
      chk("R6 ok pulse", seq_ok, m_ph == 7);
      chk("R7 fail pulse", seq_fail, m_ph == 8);
    end
  end

  task automatic retire(input logic irq);
    @(negedge clk); irq_req = irq; insn_done = 1;
    @(negedge clk); insn_done = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      if (m_ph == 0) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic core_write(input logic [15:0] ip, input logic [15:0] fl);
    @(negedge clk); core_ip_we = 1; core_ip_wdata = ip; core_flags_we = 1; core_flags_wdata = fl;
    @(negedge clk); core_ip_we = 0; core_flags_we = 0;
  endtask

  task automatic clear_logs();
    pushed.delete(); reads.delete(); push_cnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pointer", ip_out, 16'h2000);
    chk("R1 status", flags_out, 16'h0200);
    chk("R1 cycle kind", cyc_kind, 0);
    chk("R1 no request", {num_req, push_req, rd_req}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 request low -> plain end
    retire(0);
    chk("R2 end kind", cyc_kind, 1);
    chk("R2 no request", {num_req, push_req, rd_req}, 0);
    wait_idle();
    chk("R2 pointer kept", ip_out, 16'h2000);

    // R3..R6 number 5, no wait states
    clear_logs(); num_data = 8'h05;
    retire(1);
    chk("R3 phase", cyc_kind, 2);
    chk("R3 number req", num_req, 1);
    wait_idle();
    chk("R6 handler", ip_out, {memb(21), memb(20)});
    chk("R4 first push", pushed.size() > 0 ? pushed[0] : 16'hxxxx, 16'h0200);
    chk("R4 second push", pushed.size() > 1 ? pushed[1] : 16'hxxxx, 16'h2000);
    chk("R4 enable cleared", flags_out, 16'h0000);
    chk("R5 low addr", reads.size() > 0 ? reads[0] : -1, 20);
    chk("R5 high addr", reads.size() > 1 ? reads[1] : -1, 21);

    // R2 enable clear with request high
    clear_logs();
    retire(1);
    chk("R2 masked end", cyc_kind, 1);
    wait_idle();
    chk("R2 no pushes", pushed.size(), 0);

    // R5/R10 number 0xFF, all flags set, wait states
    core_write(16'h3456, 16'h0AC1);
    chk("R8 idle write ip", ip_out, 16'h3456);
    clear_logs(); num_data = 8'hFF; lat_num = 1; lat_push = 2; lat_rd = 3;
    retire(1);
    wait_idle();
    chk("R5 top low addr", reads.size() > 0 ? reads[0] : -1, 'h3FC);
    chk("R5 top high addr", reads.size() > 1 ? reads[1] : -1, 'h3FD);
    chk("R4 saved status", pushed.size() > 0 ? pushed[0] : 16'hxxxx, 16'h0AC1);
    chk("R4 saved pointer", pushed.size() > 1 ? pushed[1] : 16'hxxxx, 16'h3456);
    chk("R10 other bits kept", flags_out, 16'h08C1);
    chk("R6 top handler", ip_out, {memb('h3FD), memb('h3FC)});

    // R8/R9 writes and retire ignored mid-sequence
    core_write(16'h1000, 16'h0200);
    clear_logs(); num_data = 8'h00; lat_push = 5;
    retire(1);
    repeat (3) @(negedge clk);
    core_ip_we = 1; core_ip_wdata = 16'hDEAD; core_flags_we = 1; core_flags_wdata = 16'hFFFF;
    insn_done = 1;
    @(negedge clk);
    core_ip_we = 0; core_flags_we = 0; insn_done = 0;
    wait_idle();
    chk("R8 write ignored", ip_out, {memb(1), memb(0)});
    chk("R8 status ignored", flags_out, 16'h0000);
    chk("R9 one sequence", pushed.size(), 2);
    chk("R5 zero addr", reads.size() > 0 ? reads[0] : -1, 0);

    // R7 overflow on first push
    core_write(16'h4444, 16'h0241);
    clear_logs(); lat_push = 0; ovf_at = 0; num_data = 8'h10;
    retire(1);
    wait_idle();
    chk("R7 pointer kept", ip_out, 16'h4444);
    chk("R7 enable kept", flags_out, 16'h0241);
    chk("R7 no reads", reads.size(), 0);
    chk("R7 one push", pushed.size(), 1);

    // R7 read error on high byte
    clear_logs(); ovf_at = -1; err_addr = 'h41; lat_rd = 0;
    retire(1);
    wait_idle();
    chk("R7 pointer kept on read err", ip_out, 16'h4444);
    chk("R7 enable cleared before err", flags_out, 16'h0041);
    chk("R7 reads stop", reads.size(), 2);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule